// File: doc/BRIEF.md
# Pipelined Streaming Burst Read Master

This block is a bus read master for pipelined memory. A requester hands it a byte start address and a beat count with a one-cycle start strobe. The master opens a bus cycle and puts out a new address every cycle the slave does not stall. It does not wait for any acknowledge before moving to the next address. The burst is tagged with cycle-type code 011, which marks an incrementing burst whose address keeps running ahead of the returning acknowledges. The last address beat carries the end-of-burst code 111.

Two counters track the burst separately: one counts addresses accepted by the slave, the other counts acknowledges returned. The bus cycle stays open until the acknowledge count reaches the beat count. Each acknowledge is passed on to the requester as a one-cycle valid pulse with the captured word, in the order the addresses were issued. A completion pulse comes with the final word. Code 001 (constant-address burst, kept for I/O ports and FIFOs) and code 010 (incrementing burst that waits for each acknowledge) are never produced.

Top module: `stream_burst_rd`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_cyc`, `bus_stb`, `out_valid` and `out_done` are low.
- R2: A `go` pulse with a nonzero `go_beats` while `bus_cyc` is low raises `bus_cyc` and `bus_stb` in the next cycle, with `bus_adr` equal to `go_addr`.
- R3: A beat is accepted at a clock edge where `bus_stb` is high and `bus_stall` low; each accepted beat advances `bus_adr` by DW/8 bytes. While `bus_stall` is high, `bus_adr` and `bus_cti` hold.
- R4: `bus_cti` is 3'b011 on every beat but the last, 3'b111 on the last beat, and 3'b000 whenever `bus_stb` is low.
- R5: Exactly `go_beats` beats are accepted, at consecutive addresses; `bus_stb` falls right after the last beat is accepted.
- R6: Each acknowledge seen while `bus_cyc` is high gives `out_valid` high for one cycle in the next cycle, with `out_data` equal to the `bus_dat` sampled with that acknowledge, in issue order.
- R7: `bus_cyc` stays high until the acknowledge for the last beat, and is low in the cycle after it.
- R8: `out_done` is a single one-cycle pulse per burst, raised together with the last `out_valid`.
- R9: `go` is ignored while `bus_cyc` is high, and a `go` with `go_beats` of zero opens no bus cycle.
- R10: An acknowledge and a beat acceptance in the same cycle are both counted; no beat or word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | One-cycle burst request |
| go_addr | input | AW | Byte address of the first beat |
| go_beats | input | CW | Number of beats to read |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_stb | output | 1 | Address beat valid |
| bus_adr | output | AW | Byte address of the current beat |
| bus_cti | output | 3 | Cycle-type code of the current beat |
| bus_stall | input | 1 | Slave cannot take the beat this cycle |
| bus_ack | input | 1 | Slave returns one read word |
| bus_dat | input | DW | Read word that comes with `bus_ack` |
| out_valid | output | 1 | One-cycle pulse: `out_data` holds a word |
| out_data | output | DW | Read word for the requester |
| out_done | output | 1 | One-cycle pulse with the final word |

## Verification
Address issue and acknowledge capture run on separate counters, so one clock edge can both accept a new beat and take in the acknowledge for an earlier one. The bench's slave model returns each acknowledge a fixed number of cycles after acceptance. With a one-cycle latency and no stall, every edge in the middle of a burst does both at once. Stall patterns shift the two streams against each other. Each case is judged by comparing the accepted address sequence and the returned word sequence with lists computed from the start address. It also counts that exactly one completion pulse appears and that it comes with the last word.

// File: rtl/sbr_pkg.sv
// Package: shared cycle-type codes for the streaming burst read master.
// Assumes a 3-bit cycle-type field on the bus.
package sbr_pkg;
    typedef enum logic [2:0] {
        CTI_CLASSIC = 3'b000,  // no burst / no beat on the bus
        CTI_CONST   = 3'b001,  // constant-address burst (never produced here)
        CTI_INCR    = 3'b010,  // incrementing burst that waits for ack (never produced)
        CTI_PIPE    = 3'b011,  // pipelined incrementing burst, address runs ahead
        CTI_END     = 3'b111   // final beat of a burst
    } cti_e;
endpackage

// File: rtl/sbr_issue.sv
// Address issue unit: drives strobe, address and cycle type for one burst.
// Counts accepted beats (strobe high, stall low). Assumes `launch` only
// arrives while no burst is active and `total` is nonzero after launch.
module sbr_issue
    import sbr_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 8,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] total,
    input  logic          stall,
    output logic          stb,
    output logic [AW-1:0] adr,
    output cti_e          cti,
    output logic [CW-1:0] issued
);
    localparam logic [AW-1:0] ADR_STEP = AW'(STEP);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic          stb_q;
    logic [AW-1:0] adr_q;
    logic [CW-1:0] issued_q;
    logic          last_beat;
    logic          accept;

    assign last_beat = (issued_q == total - ONE);
    assign accept    = stb_q && !stall;

    // Purpose: open the address phase, advance one beat per accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q    <= 1'b0;
            adr_q    <= '0;
            issued_q <= '0;
        end else if (launch) begin
            stb_q    <= 1'b1;
            adr_q    <= base;
            issued_q <= '0;
        end else if (accept) begin
            issued_q <= issued_q + ONE;
            adr_q    <= adr_q + ADR_STEP;
            if (last_beat) stb_q <= 1'b0;
        end
    end

    // Purpose: tag each beat with its cycle-type code.
    always_comb begin
        if (!stb_q)         cti = CTI_CLASSIC;
        else if (last_beat) cti = CTI_END;
        else                cti = CTI_PIPE;
    end

    assign stb    = stb_q;
    assign adr    = adr_q;
    assign issued = issued_q;

    assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && stall && !launch) |=> (stb && $stable(adr) && $stable(cti)));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !last_beat && !launch) |=> (adr == $past(adr) + ADR_STEP));

    assert_stb_ends_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && cti == CTI_END && !stall) |=> !stb);
endmodule

// File: rtl/sbr_ack.sv
// Acknowledge tracker: owns the bus cycle flag, counts returned acks,
// forwards each word as a one-cycle valid and flags the final one.
// Assumes the slave never acks more beats than were accepted.
module sbr_ack #(
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [CW-1:0] total,
    input  logic          ack,
    input  logic [DW-1:0] dat,
    output logic          active,
    output logic [CW-1:0] acked,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic          cyc_q;
    logic [CW-1:0] acked_q;
    logic          valid_q;
    logic [DW-1:0] data_q;
    logic          done_q;
    logic          take;
    logic          final_ack;

    assign take      = cyc_q && ack;
    assign final_ack = take && (acked_q == total - ONE);

    // Purpose: hold the bus cycle open and count acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= 1'b0;
            acked_q <= '0;
        end else if (launch) begin
            cyc_q   <= 1'b1;
            acked_q <= '0;
        end else if (take) begin
            acked_q <= acked_q + ONE;
            if (final_ack) cyc_q <= 1'b0;
        end
    end

    // Purpose: register each returned word and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= take;
            done_q  <= final_ack;
            if (take) data_q <= dat;
        end
    end

    assign active   = cyc_q;
    assign acked    = acked_q;
    assign rd_valid = valid_q;
    assign rd_data  = data_q;
    assign done     = done_q;

    assert_done_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_valid);

    assert_cyc_needs_ack_to_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ack) |=> active);

    assert_valid_follows_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ack) |=> rd_valid);
endmodule

// File: rtl/stream_burst_rd.sv
// Streaming burst read master top. Accepts a burst request, latches the
// beat count and runs the address issue and ack tracking units in parallel.
// Assumes a slave that returns acks in issue order, never more than issued.
module stream_burst_rd
    import sbr_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] go_addr,
    input  logic [CW-1:0] go_beats,
    output logic          bus_cyc,
    output logic          bus_stb,
    output logic [AW-1:0] bus_adr,
    output logic [2:0]    bus_cti,
    input  logic          bus_stall,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_dat,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_done
);
    localparam int STEP = DW / 8;

    logic          launch;
    logic [CW-1:0] total_q;
    logic [CW-1:0] issued;
    logic [CW-1:0] acked;
    logic          active;
    cti_e          cti;

    assign launch = go && !active && (go_beats != '0);

    // Purpose: keep the beat count of the running burst.
    always_ff @(posedge clk) begin
        if (!rst_n)      total_q <= '0;
        else if (launch) total_q <= go_beats;
    end

    sbr_issue #(.AW(AW), .CW(CW), .STEP(STEP)) u_issue (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .base   (go_addr),
        .total  (total_q),
        .stall  (bus_stall),
        .stb    (bus_stb),
        .adr    (bus_adr),
        .cti    (cti),
        .issued (issued)
    );

    sbr_ack #(.DW(DW), .CW(CW)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .total    (total_q),
        .ack      (bus_ack),
        .dat      (bus_dat),
        .active   (active),
        .acked    (acked),
        .rd_valid (out_valid),
        .rd_data  (out_data),
        .done     (out_done)
    );

    assign bus_cyc = active;
    assign bus_cti = cti;

    assert_stb_within_cyc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> bus_cyc);

    assert_acks_behind_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (acked <= issued));

    assert_go_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && go) |=> $stable(total_q));
endmodule

// File: tb/sim_stream_burst_rd.sv
module sim_stream_burst_rd;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;
    localparam int NV = 5;

    // Vector table: start address, beat count, stall pattern, ack latency
    localparam logic [31:0] T_ADDR [NV] = '{32'h0000_1000, 32'h2000_0040, 32'h0000_00FC, 32'h0000_3000, 32'hFFFF_FFF0};
    localparam int          T_N    [NV] = '{8, 5, 1, 12, 6};
    localparam logic [15:0] T_PAT  [NV] = '{16'h0000, 16'hA5A5, 16'h0000, 16'h0F0F, 16'h1111};
    localparam int          T_LAT  [NV] = '{1, 2, 3, 4, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [AW-1:0] go_addr = '0;
    logic [CW-1:0] go_beats = '0;
    logic          bus_cyc, bus_stb, out_valid, out_done;
    logic [AW-1:0] bus_adr;
    logic [2:0]    bus_cti;
    logic          bus_stall = 1'b0;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_dat = '0;
    logic [DW-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;

    // Burst context used by the slave model and monitors
    logic [31:0] e_base = '0;
    int          e_n = 0;
    logic [15:0] e_pat = '0;
    int          e_lat = 1;
    int          n_acc = 0;
    int          n_rd = 0;
    int          n_done = 0;
    int          n_coll = 0;
    int          win = 0;
    logic [31:0] q_addr [64];
    int          q_due  [64];
    int          qh = 0;
    int          qt = 0;

    stream_burst_rd #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .go_beats(go_beats),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_adr(bus_adr), .bus_cti(bus_cti),
        .bus_stall(bus_stall), .bus_ack(bus_ack), .bus_dat(bus_dat),
        .out_valid(out_valid), .out_data(out_data), .out_done(out_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] resp(input logic [31:0] a);
        return {a[15:0] ^ 16'h3C3C, ~a[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Slave model and monitors, all evaluated away from the rising edge
    always @(negedge clk) begin
        win++;
        bus_stall = e_pat[win % 16];
        if (qh < qt && q_due[qh % 64] == win) begin
            bus_ack = 1'b1;
            bus_dat = resp(q_addr[qh % 64]);
            qh++;
        end else begin
            bus_ack = 1'b0;
            bus_dat = '0;
        end
        if (bus_stb && !bus_stall) begin
            // R3 R5: accepted beat sits at the next consecutive address
            check(bus_adr == e_base + 32'(n_acc * 4), "R3/R5 beat address", bus_adr, e_base + 32'(n_acc * 4));
            // R4: 111 on the last beat, 011 on the others
            check(bus_cti == ((n_acc == e_n - 1) ? 3'b111 : 3'b011), "R4 beat cti", 32'(bus_cti),
                  (n_acc == e_n - 1) ? 32'h7 : 32'h3);
            if (bus_ack) n_coll++;
            q_addr[qt % 64] = bus_adr;
            q_due[qt % 64]  = win + e_lat;
            qt++;
            n_acc++;
        end
        if (bus_cyc && !bus_stb)
            check(bus_cti == 3'b000, "R4 cti idle between beats", 32'(bus_cti), 32'h0);
        if (out_valid) begin
            // R6: words arrive in issue order with the acked data
            check(out_data == resp(e_base + 32'(n_rd * 4)), "R6 read word", out_data, resp(e_base + 32'(n_rd * 4)));
            n_rd++;
        end
        if (out_done) begin
            n_done++;
            // R8: done pulse comes with the last word
            check(out_valid && n_rd == e_n, "R8 done with last word", 32'(n_rd), 32'(e_n));
            // R7: cycle already closed after the final ack
            check(!bus_cyc && !bus_stb, "R7 cyc low after last ack", {31'b0, bus_cyc}, 32'h0);
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic run_burst(input logic [31:0] a, input int n, input logic [15:0] pat, input int lat, input bit poke);
        int t;
        @(negedge clk);
        e_base = a; e_n = n; e_pat = pat; e_lat = lat;
        n_acc = 0; n_rd = 0; n_done = 0;
        go = 1'b1; go_addr = a; go_beats = CW'(n);
        @(negedge clk);
        go = 1'b0;
        // R2: bus cycle opened at the requested address
        check(bus_cyc && bus_stb && bus_adr == a, "R2 burst open", bus_adr, a);
        if (poke) begin
            @(negedge clk);
            go = 1'b1; go_addr = a ^ 32'h0001_0000; go_beats = CW'(3);
            @(negedge clk);
            go = 1'b0;
        end
        t = 0;
        while (n_done == 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        check(n_acc == n, "R5 beats issued", 32'(n_acc), 32'(n));
        check(n_rd == n, "R6 words returned", 32'(n_rd), 32'(n));
        check(n_done == 1, "R8 single done", 32'(n_done), 32'h1);
        check(!bus_cyc, "R7 cyc closed", {31'b0, bus_cyc}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held
        check(!bus_cyc && !bus_stb && !out_valid && !out_done, "R1 reset held",
              {28'b0, bus_cyc, bus_stb, out_valid, out_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_cyc && !bus_stb && !out_valid && !out_done, "R1 after reset",
              {28'b0, bus_cyc, bus_stb, out_valid, out_done}, 32'h0);

        for (int i = 0; i < NV; i++)
            run_burst(T_ADDR[i], T_N[i], T_PAT[i], T_LAT[i], 1'b0);

        // R10: one-cycle latency without stall overlaps ack and accept
        check(n_coll > 0, "R10 ack and accept same cycle", 32'(n_coll), 32'h1);

        // R9: go during a burst changes nothing
        run_burst(32'h0000_8000, 7, 16'h0000, 2, 1'b1);

        // R9: zero beat count opens no cycle
        @(negedge clk);
        e_pat = '0;
        go = 1'b1; go_addr = 32'h0000_9000; go_beats = '0;
        @(negedge clk);
        go = 1'b0;
        repeat (2) @(negedge clk);
        check(!bus_cyc && !bus_stb, "R9 zero-beat go ignored", {30'b0, bus_cyc, bus_stb}, 32'h0);

        // R3: long stall run holds the address, then the burst completes
        run_burst(32'h0000_A000, 4, 16'h7FFE, 1, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule